// File: doc/BRIEF.md
# Linked-Descriptor Transfer Sequencer

This block drives a list of transfer descriptors kept in memory. Software places the byte address of the first descriptor into a pointer register and then sets a run bit. The sequencer reads the descriptor one word at a time over a request/acknowledge memory port. Each descriptor holds a link to the following descriptor, NSRC source addresses, a destination address, a byte count and a command word. Once all of a descriptor's words are in, the sequencer presents them to a downstream datapath with a valid/ready handshake. It then follows the link, and stops when it meets a zero link.

Completion is reported through three sticky status causes and a level interrupt. A descriptor with bit 0 of its command word set raises a cause when the datapath accepts it. The cause is "chain end" when that descriptor's link is zero and "descriptor end" otherwise. An error answer from memory records a bus-error cause and halts the walk, whether or not any descriptor asked for an interrupt. Software halts the walk early by writing 0 to the run bit. The pointer register then still names the descriptor that was not yet handed off, so setting the run bit again resumes from there.

Register map (word index on `reg_addr`): 0 = control (bit 0 run), 1 = status (bit 0 chain end, bit 1 descriptor end, bit 2 bus error, bit 3 busy, read only), 2 = descriptor pointer. Descriptor word k is at pointer + 4k, in this order: link, sources 0..NSRC-1, destination, count, command.

Top module: `desc_chain_ctrl`

## Requirements
- R1: After reset the control, status and pointer registers read 0, and `irq`, `mem_req` and `job_valid` are low.
- R2: The pointer register always reads with bits [4:0] zero, and every descriptor fetch starts at an address with bits [4:0] zero. A pointer write while busy is ignored.
- R3: Starting from idle, the sequencer reads exactly NSRC+4 words per descriptor at consecutive word addresses from the pointer. It holds `mem_req` and `mem_addr` steady until `mem_ack` or `mem_err`.
- R4: Once all of a descriptor's words are in, `job_valid` rises and stays high with steady fields until `job_ready`. `job_src` carries source i in bits [i*W +: W], alongside the destination, count and command words.
- R5: After each handoff the pointer takes the descriptor's link. A zero link ends the walk: busy (status bit 3) and the run bit clear, and no memory request or job stays pending.
- R6: A handed-off descriptor whose command bit 0 is set sets status bit 0 if its link is zero, and status bit 1 otherwise. A descriptor with command bit 0 clear sets neither.
- R7: `irq` is high exactly when any of status bits 0, 1 or 2 is set.
- R8: Writing status clears each cause whose written bit is 1 and leaves the others. A cause being set in the same cycle wins over the clear.
- R9: A `mem_err` answer sets status bit 2, ends the walk at once without handing off that descriptor, clears the run bit and raises `irq`.
- R10: Writing 1 to the run bit while busy is ignored: it neither restarts the fetch nor adds memory reads.
- R11: Writing 0 to the run bit while busy halts the walk. A read in flight is completed first, a pending job is withdrawn, no cause is set, and the pointer keeps the descriptor that was not handed off.
- R12: Setting the run bit while the pointer is zero is ignored: no memory request, and the run bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | W | Memory byte address |
| mem_rdata | input | W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory read completed |
| mem_err | input | 1 | Memory read failed |
| job_valid | output | 1 | Descriptor work offered to datapath |
| job_ready | input | 1 | Datapath accepts the work |
| job_src | output | NSRC*W | Source addresses |
| job_dst | output | W | Destination address |
| job_count | output | W | Byte count |
| job_cmd | output | W | Command word |
| irq | output | 1 | Interrupt, level |

## Verification
The properties assume that `mem_ack` and `mem_err` come only while `mem_req` is high, never both at once, and once per request. They also assume `job_ready` is only a single-cycle pulse while `job_valid` is high. The bench's memory and datapath models register their answers and never reply twice in a row, which keeps within those rules. Descriptor images are placed at 32-byte boundaries with links that are aligned or zero, and the error case injects one failing word inside a chain.

// File: rtl/desc_chain_ctrl.sv
module desc_chain_ctrl #(
  parameter int W     = 32,
  parameter int NSRC  = 4,
  parameter int ALIGN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              mem_req,
  output logic [W-1:0]      mem_addr,
  input  logic [W-1:0]      mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              job_valid,
  input  logic              job_ready,
  output logic [NSRC*W-1:0] job_src,
  output logic [W-1:0]      job_dst,
  output logic [W-1:0]      job_count,
  output logic [W-1:0]      job_cmd,
  output logic              irq
);

  localparam int NW = NSRC + 4;
  localparam int IW = $clog2(NW);
  localparam int SH = $clog2(W / 8);
  localparam logic [W-1:0]  AMASK = {{(W-ALIGN){1'b1}}, {ALIGN{1'b0}}};
  localparam logic [IW-1:0] LASTW = IW'(NW - 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ISSUE} state_t;

  state_t        st;
  logic          en;
  logic [2:0]    sts;
  logic [W-1:0]  nda;
  logic [IW-1:0] widx;
  logic [W-1:0]  words [NW];

  logic          active, wr_ctrl, wr_stat, wr_nda, start, stop, done;
  logic [W-1:0]  next_ptr;
  logic          next_zero;
  logic [2:0]    sts_set, sts_clr;

  assign active    = (st != S_IDLE);
  assign wr_ctrl   = reg_we && (reg_addr == 2'd0);
  assign wr_stat   = reg_we && (reg_addr == 2'd1);
  assign wr_nda    = reg_we && (reg_addr == 2'd2);
  assign start     = wr_ctrl && reg_wdata[0] && !active && (nda != '0);
  assign stop      = wr_ctrl && !reg_wdata[0];
  assign next_ptr  = words[0] & AMASK;
  assign next_zero = (next_ptr == '0);

  assign mem_req   = (st == S_FETCH);
  assign mem_addr  = nda + (W'(widx) << SH);
  assign job_valid = (st == S_ISSUE) && en;
  assign done      = job_valid && job_ready;

  assign sts_set[0] = done && job_cmd[0] && next_zero;
  assign sts_set[1] = done && job_cmd[0] && !next_zero;
  assign sts_set[2] = (st == S_FETCH) && mem_err;
  assign sts_clr    = wr_stat ? reg_wdata[2:0] : 3'b000;
  assign irq        = |sts;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign job_src[g*W +: W] = words[1+g];
  end
  assign job_dst   = words[NSRC+1];
  assign job_count = words[NSRC+2];
  assign job_cmd   = words[NSRC+3];

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {{(W-1){1'b0}}, en};
      2'd1:    reg_rdata = {{(W-4){1'b0}}, active, sts};
      2'd2:    reg_rdata = nda;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      en   <= 1'b0;
      sts  <= '0;
      nda  <= '0;
      widx <= '0;
      for (int i = 0; i < NW; i++) words[i] <= '0;
    end else begin
      sts <= (sts & ~sts_clr) | sts_set;
      if (wr_nda && !active) nda <= reg_wdata & AMASK;
      if (stop) en <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            en   <= 1'b1;
            widx <= '0;
            st   <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_err) begin
            en <= 1'b0;
            st <= S_IDLE;
          end else if (mem_ack) begin
            words[widx] <= mem_rdata;
            if (!en)                st   <= S_IDLE;
            else if (widx == LASTW) st   <= S_ISSUE;
            else                    widx <= widx + 1'b1;
          end
        end
        S_ISSUE: begin
          if (!en) begin
            st <= S_IDLE;
          end else if (job_ready) begin
            nda <= next_ptr;
            if (next_zero) begin
              en <= 1'b0;
              st <= S_IDLE;
            end else begin
              widx <= '0;
              st   <= S_FETCH;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module desc_chain_ctrl_chk #(
  parameter int W     = 32,
  parameter int ALIGN = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mem_req,
  input logic [W-1:0] mem_addr,
  input logic         mem_ack,
  input logic         mem_err,
  input logic         job_valid,
  input logic         job_ready,
  input logic [W-1:0] job_dst,
  input logic         ie,
  input logic         irq,
  input logic         en,
  input logic         active,
  input logic [2:0]   sts,
  input logic         next_zero
);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !mem_err |=> mem_req && $stable(mem_addr));

  assert_fetch_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (mem_addr[ALIGN-1:0] == '0));

  assert_job_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && !job_ready |=> (job_valid || !en) && $stable(job_dst));

  assert_err_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_err |=> !active && sts[2] && irq);

  assert_chain_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && job_ready && ie && next_zero |=> sts[0] && !active);

  assert_desc_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && job_ready && ie && !next_zero |=> sts[1] && active);

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mem_req && !job_valid);

endmodule

bind desc_chain_ctrl desc_chain_ctrl_chk #(.W(W), .ALIGN(ALIGN)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .mem_err(mem_err), .job_valid(job_valid),
  .job_ready(job_ready), .job_dst(job_dst), .ie(job_cmd[0]), .irq(irq),
  .en(en), .active(active), .sts(sts), .next_zero(next_zero)
);

// File: tb/desc_chain_ctrl_tb.sv
`timescale 1ns/1ps
module desc_chain_ctrl_tb;
  localparam int W = 32;
  localparam int NSRC = 4;
  localparam int NW = NSRC + 4;
  localparam int JW = W * (NW - 1);
  // {count, ie mask, memory latency, ready delay, expected status}
  localparam logic [23:0] VEC [5] = '{24'h101001, 24'h304121, 24'h303212,
                                      24'h40F033, 24'h200300};

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [W-1:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_ack, mem_err;
  logic [W-1:0] mem_addr, mem_rdata;
  logic job_valid, job_ready;
  logic [NSRC*W-1:0] job_src;
  logic [W-1:0] job_dst, job_count, job_cmd;
  logic irq;

  always #4 clk = ~clk;

  desc_chain_ctrl u_dut (.*);

  logic [31:0] mem [0:1023];
  int lat = 0, rdly = 0, wcnt = 0, rcnt = 0;
  logic dp_block = 0;
  logic [W-1:0] err_addr = 32'hFFFF_FFFC;
  int checks = 0, errors = 0, hcount = 0, rdcount = 0, cyc = 0;
  logic [JW-1:0] cap [64];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; mem_err <= 0; mem_rdata <= 0; wcnt <= 0;
    end else begin
      mem_ack <= 0; mem_err <= 0;
      if (mem_req && !mem_ack && !mem_err) begin
        if (wcnt >= lat) begin
          wcnt <= 0;
          if (mem_addr == err_addr) mem_err <= 1;
          else begin mem_ack <= 1; mem_rdata <= mem[mem_addr[11:2]]; end
        end else wcnt <= wcnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin job_ready <= 0; rcnt <= 0; end
    else begin
      job_ready <= 0;
      if (job_valid && !job_ready && !dp_block) begin
        if (rcnt >= rdly) begin job_ready <= 1; rcnt <= 0; end
        else rcnt <= rcnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (job_valid && job_ready) begin
      cap[hcount] <= {job_cmd, job_count, job_dst, job_src};
      hcount <= hcount + 1;
    end
    if (mem_req && mem_ack) rdcount <= rdcount + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  function automatic logic [W-1:0] base(int s);
    return W'(32'h100 * (s + 1));
  endfunction

  function automatic logic [W-1:0] dword(int s, int k, int j, int n, logic [7:0] ie);
    logic [W-1:0] p;
    p = {8'(8'hC0 + s), 8'(k), 8'(j), 8'h5A};
    if (j == 0) return (k == n - 1) ? '0 : base(s) + W'(32 * (k + 1));
    if (j == NW - 1) return {p[W-1:1], ie[k]};
    return p;
  endfunction

  function automatic logic [JW-1:0] exp_job(int s, int k, int n, logic [7:0] ie);
    logic [JW-1:0] v;
    for (int j = 1; j < NW; j++) v[(j-1)*W +: W] = dword(s, k, j, n, ie);
    return v;
  endfunction

  task automatic load_chain(int s, int n, logic [7:0] ie);
    for (int k = 0; k < n; k++)
      for (int j = 0; j < NW; j++)
        mem[(base(s) >> 2) + 8 * k + j] = dword(s, k, j, n, ie);
  endtask

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_job(string tag, int idx, logic [JW-1:0] exp);
    checks++;
    if (cap[idx] !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, cap[idx], exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); reg_addr = 1; #1;
      if (!reg_rdata[3]) break;
    end
  endtask

  logic [W-1:0] rd;
  int h0, r0;

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    reg_read(0, rd); chk("R1 ctrl", rd, 0);
    reg_read(1, rd); chk("R1 status", rd, 0);
    reg_read(2, rd); chk("R1 pointer", rd, 0);
    chk("R1 irq/req/valid", {29'd0, irq, mem_req, job_valid}, 0);

    // R2 pointer alignment
    reg_write(2, 32'h0001_2345);
    reg_read(2, rd); chk("R2 pointer low bits", rd, 32'h0001_2340);
    reg_read(3, rd); chk("R2 unused index", rd, 0);

    // R12 start with zero pointer
    reg_write(2, 0);
    r0 = rdcount;
    reg_write(0, 1);
    repeat (4) @(negedge clk);
    chk("R12 no reads", W'(rdcount - r0), 0);
    reg_read(0, rd); chk("R12 run bit", rd, 0);
    reg_read(1, rd); chk("R12 status", rd, 0);

    // table of chains: R3 R4 R5 R6 R7 R8 R10
    foreach (VEC[v]) begin
      int n; logic [7:0] ie; logic [3:0] ex;
      n = int'(VEC[v][23:20]); ie = VEC[v][19:12];
      ex = VEC[v][3:0];
      load_chain(v, n, ie);
      lat = int'(VEC[v][11:8]); rdly = int'(VEC[v][7:4]);
      h0 = hcount; r0 = rdcount;
      reg_write(2, base(v));
      reg_write(0, 1);
      reg_write(0, 1);          // R10 ignored while busy
      reg_write(2, 32'h7E0);    // R2 ignored while busy
      wait_idle();
      chk("R5 handoff count", W'(hcount - h0), W'(n));
      for (int k = 0; k < n; k++) chk_job("R4 job fields", h0 + k, exp_job(v, k, n, ie));
      chk("R3 R10 read count", W'(rdcount - r0), W'(n * NW));
      reg_read(1, rd); chk("R6 status causes", rd, W'(ex));
      chk("R7 irq", W'(irq), W'(ex != 0));
      reg_read(0, rd); chk("R5 run bit cleared", rd, 0);
      reg_read(2, rd); chk("R2 R5 pointer at end", rd, 0);
      reg_write(1, 32'h7);
      reg_read(1, rd); chk("R8 cleared", rd, 0);
      chk("R7 irq after clear", W'(irq), 0);
    end

    // R9 bus error in second descriptor, word 3
    load_chain(6, 3, 8'h00);
    lat = 0; rdly = 0;
    err_addr = base(6) + 32 + 12;
    h0 = hcount; r0 = rdcount;
    reg_write(2, base(6));
    reg_write(0, 1);
    wait_idle();
    chk("R9 handoffs", W'(hcount - h0), 1);
    chk("R9 reads", W'(rdcount - r0), W'(NW + 3));
    reg_read(1, rd); chk("R9 status", rd, 32'h4);
    chk("R9 irq", W'(irq), 1);
    reg_read(0, rd); chk("R9 run bit", rd, 0);
    reg_read(2, rd); chk("R9 pointer", rd, base(6) + 32);
    reg_write(1, 32'h3);
    reg_read(1, rd); chk("R8 other bits kept", rd, 32'h4);
    reg_write(1, 32'h4);
    reg_read(1, rd); chk("R8 error cleared", rd, 0);
    err_addr = 32'hFFFF_FFFC;

    // R11 stop while a job waits, then resume
    load_chain(7, 3, 8'h04);
    dp_block = 1;
    h0 = hcount;
    reg_write(2, base(7));
    reg_write(0, 1);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (job_valid) break;
    end
    reg_write(0, 0);
    @(negedge clk);
    chk("R11 job withdrawn", W'(job_valid), 0);
    reg_read(1, rd); chk("R11 idle no cause", rd, 0);
    chk("R11 no handoff", W'(hcount - h0), 0);
    reg_read(2, rd); chk("R11 pointer kept", rd, base(7));
    dp_block = 0;
    reg_write(0, 1);
    wait_idle();
    chk("R11 resumed handoffs", W'(hcount - h0), 3);
    for (int k = 0; k < 3; k++) chk_job("R11 resumed fields", h0 + k, exp_job(7, k, 3, 8'h04));
    reg_read(1, rd); chk("R11 R6 chain end", rd, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule